// File: doc/BRIEF.md
# Edge/Level Interrupt Request Front End

This block sits in front of a small interrupt controller and turns two raw request sources into request flags that the CPU can see, accept and clear. The first source is an external pin, brought into the clock domain through a flip-flop synchronizer. Software picks whether that pin is edge-triggered or level-sensitive. The second source is a serial-receive event. Its flag is normally cleared by the read of the receive buffer, which is modelled here as a read strobe.

Software controls the block through a two-register write port. Address 0 is the mode register: bit 0 selects level mode for the pin, and bit 1 lets clear-register writes act on the receive flag. Address 1 is the clear register, and writing a source code to it clears that source's flag.

The CPU side has two strobes. The accept strobe records which source won, with the pin ranked above the receive source. The vector-read strobe then returns that source's vector. If the recorded request has gone away in the meantime, it returns the default vector instead.

Top module: `irq_front`

## Requirements
- R1: Reset clears both flags and the mode register, which selects edge mode with the receive clear disabled. After reset `ext_req`, `rx_req` and `vec_valid` are 0.
- R2: In edge mode (mode bit 0 = 0), a 0-to-1 change of the synchronized pin sets `ext_req`. `ext_req` stays 1 after the pin returns low, until a clear.
- R3: In level mode (mode bit 0 = 1), `ext_req` equals the synchronized pin level, so a high-to-low change of the pin withdraws the request.
- R4: A mode write that moves the pin from edge to level mode clears the pin's latched flag. Returning to edge mode without any pin activity leaves `ext_req` at 0.
- R5: While the pin is high in level mode, the flag is set. A switch back to edge mode keeps that flag, so `ext_req` stays 1 with the pin low until code 0x0A is written to the clear register.
- R6: In edge mode, writing 0x0A to the clear register (address 1) clears the pin flag. Writing any other code, such as 0x0B, leaves it set.
- R7: A pulse on `rx_event` sets `rx_req`, and a pulse on `rx_buf_rd` clears it.
- R8: With mode bit 1 = 0, writing the receive clear code 0x0B to address 1 has no effect on `rx_req`.
- R9: With mode bit 1 = 1, writing 0x0B to address 1 clears `rx_req`.
- R10: `accept` records the pin source if `ext_req` is 1, otherwise the receive source if `rx_req` is 1. The next `vec_rd` returns the vector of the recorded source (0x0028 for the pin, 0x0030 for receive) on `vec_out`, one cycle after the strobe.
- R11: If the recorded source's request is 0 when `vec_rd` is sampled, `vec_out` returns 0x0004.
- R12: `vec_valid` is 1 only in the cycle after a `vec_rd` strobe. A `vec_rd` with no accept recorded since the previous read returns 0x0004.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Asynchronous external interrupt pin |
| rx_event | input | 1 | Serial-receive request pulse |
| rx_buf_rd | input | 1 | Receive-buffer read strobe (clears receive flag) |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 1 | 0 = mode register, 1 = clear register |
| wr_data | input | 8 | Write data |
| accept | input | 1 | CPU accepts the highest pending request |
| vec_rd | input | 1 | CPU reads the vector of the accepted request |
| ext_req | output | 1 | Pin request to the controller |
| rx_req | output | 1 | Receive request to the controller |
| vec_out | output | 16 | Vector returned by the last read |
| vec_valid | output | 1 | `vec_out` updated this cycle |

## Verification
The hardest case to reach is a request that goes away in the short gap between acceptance and the vector read. From the ports, that gap only exists if the bench drives the strobes one cycle apart. The bench accepts a pending receive request, spends the next cycle on a receive-buffer read, and then strobes the vector read, expecting the default vector. A second hard case is a flag that was latched in level mode and survives the return to edge mode. To reach it, the bench holds the pin high through a level-mode interval, lowers the pin, and switches the mode back before clearing.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_RX   = 2'd2
  } src_e;

  typedef struct packed {
    logic rx_clr_en;
    logic ext_lvl;
  } mode_t;

  localparam logic ADDR_MODE = 1'b0;
  localparam logic ADDR_CLR  = 1'b1;

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= 1'b0;
      else     chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_ext_src.sv
module irq_ext_src (
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  input  logic lvl_mode,
  input  logic lvl_enter,
  input  logic clr_hit,
  output logic flag,
  output logic req
);
  logic pin_d;
  logic set_cond;

  always_ff @(posedge clk) begin
    if (rst) pin_d <= 1'b0;
    else     pin_d <= pin_s;
  end

  // Level mode: set input passes through; edge mode: rising edge only.
  assign set_cond = lvl_mode ? pin_s : (pin_s & ~pin_d);

  always_ff @(posedge clk) begin
    if (rst)            flag <= 1'b0;
    else if (lvl_enter) flag <= 1'b0;
    else if (set_cond)  flag <= 1'b1;
    else if (clr_hit)   flag <= 1'b0;
  end

  assign req = lvl_mode ? pin_s : flag;
endmodule

// File: rtl/irq_rx_src.sv
module irq_rx_src (
  input  logic clk,
  input  logic rst,
  input  logic rx_event,
  input  logic rx_buf_rd,
  input  logic clr_hit,
  input  logic clr_en,
  output logic req
);
  always_ff @(posedge clk) begin
    if (rst)                   req <= 1'b0;
    else if (rx_event)         req <= 1'b1;
    else if (rx_buf_rd)        req <= 1'b0;
    else if (clr_hit && clr_en) req <= 1'b0;
  end
endmodule

// File: rtl/irq_vector_port.sv
module irq_vector_port
  import irq_pkg::*;
#(
  parameter int               VEC_W    = 16,
  parameter logic [VEC_W-1:0] EXT_VEC  = 16'h0028,
  parameter logic [VEC_W-1:0] RX_VEC   = 16'h0030,
  parameter logic [VEC_W-1:0] DFLT_VEC = 16'h0004
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             vec_rd,
  input  logic             ext_req,
  input  logic             rx_req,
  output logic [VEC_W-1:0] vec_out,
  output logic             vec_valid
);
  src_e             acc_src;
  logic [VEC_W-1:0] vec_sel;

  always_comb begin
    vec_sel = DFLT_VEC;
    case (acc_src)
      SRC_EXT: if (ext_req) vec_sel = EXT_VEC;
      SRC_RX:  if (rx_req)  vec_sel = RX_VEC;
      default: vec_sel = DFLT_VEC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_src   <= SRC_NONE;
      vec_out   <= '0;
      vec_valid <= 1'b0;
    end else begin
      vec_valid <= vec_rd;
      if (vec_rd) begin
        vec_out <= vec_sel;
        acc_src <= SRC_NONE;
      end
      if (accept) begin
        if (ext_req)     acc_src <= SRC_EXT;
        else if (rx_req) acc_src <= SRC_RX;
        else             acc_src <= SRC_NONE;
      end
    end
  end
endmodule

// File: rtl/irq_front.sv
module irq_front
  import irq_pkg::*;
#(
  parameter int                DATA_W      = 8,
  parameter int                VEC_W       = 16,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] EXT_CODE    = 8'h0A,
  parameter logic [DATA_W-1:0] RX_CODE     = 8'h0B,
  parameter logic [VEC_W-1:0]  EXT_VEC     = 16'h0028,
  parameter logic [VEC_W-1:0]  RX_VEC      = 16'h0030,
  parameter logic [VEC_W-1:0]  DFLT_VEC    = 16'h0004
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_in,
  input  logic              rx_event,
  input  logic              rx_buf_rd,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              accept,
  input  logic              vec_rd,
  output logic              ext_req,
  output logic              rx_req,
  output logic [VEC_W-1:0]  vec_out,
  output logic              vec_valid
);
  mode_t mode_q;
  logic  ext_lvl, rx_clr_en;
  logic  mode_wr, clr_wr, lvl_enter;
  logic  ext_clr_hit, rx_clr_hit;
  logic  pin_s, ext_flag;

  assign mode_wr     = wr_en && (wr_addr == ADDR_MODE);
  assign clr_wr      = wr_en && (wr_addr == ADDR_CLR);
  assign ext_clr_hit = clr_wr && (wr_data == EXT_CODE);
  assign rx_clr_hit  = clr_wr && (wr_data == RX_CODE);
  assign lvl_enter   = mode_wr && wr_data[0] && !mode_q.ext_lvl;

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= '0;
    else if (mode_wr) mode_q <= mode_t'(wr_data[1:0]);
  end

  assign ext_lvl   = mode_q.ext_lvl;
  assign rx_clr_en = mode_q.rx_clr_en;

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
  );

  irq_ext_src u_ext (
    .clk(clk), .rst(rst), .pin_s(pin_s), .lvl_mode(ext_lvl),
    .lvl_enter(lvl_enter), .clr_hit(ext_clr_hit),
    .flag(ext_flag), .req(ext_req)
  );

  irq_rx_src u_rx (
    .clk(clk), .rst(rst), .rx_event(rx_event), .rx_buf_rd(rx_buf_rd),
    .clr_hit(rx_clr_hit), .clr_en(rx_clr_en), .req(rx_req)
  );

  irq_vector_port #(
    .VEC_W(VEC_W), .EXT_VEC(EXT_VEC), .RX_VEC(RX_VEC), .DFLT_VEC(DFLT_VEC)
  ) u_vec (
    .clk(clk), .rst(rst), .accept(accept), .vec_rd(vec_rd),
    .ext_req(ext_req), .rx_req(rx_req),
    .vec_out(vec_out), .vec_valid(vec_valid)
  );
endmodule

// File: rtl/irq_front_chk.sv
module irq_front_chk #(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] EXT_CODE = 8'h0A
) (
  input logic              clk,
  input logic              rst,
  input logic              ext_req,
  input logic              rx_req,
  input logic              vec_valid,
  input logic              vec_rd,
  input logic              wr_en,
  input logic              wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rx_event,
  input logic              rx_buf_rd,
  input logic              ext_lvl,
  input logic              rx_clr_en,
  input logic              ext_flag,
  input logic              pin_s
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!ext_req && !rx_req && !vec_valid));

  p_edge_hold_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(ext_req) && !ext_lvl && !$past(ext_lvl)
     && !$past(wr_en && wr_addr && (wr_data == EXT_CODE))) |-> ext_req);

  p_level_low_r3: assert property (@(posedge clk) disable iff (rst)
    (ext_lvl && !pin_s) |-> !ext_req);

  p_mode_clear_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ext_lvl) |-> !ext_flag);

  p_rx_read_clear_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(rx_buf_rd) && !$past(rx_event)) |-> !rx_req);

  p_rx_lvl_hold_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(rx_req) && !$past(rx_clr_en) && !$past(rx_buf_rd)) |-> rx_req);

  p_vec_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(vec_rd));
endmodule

bind irq_front irq_front_chk #(.DATA_W(DATA_W), .EXT_CODE(EXT_CODE)) u_chk (
  .clk(clk), .rst(rst), .ext_req(ext_req), .rx_req(rx_req),
  .vec_valid(vec_valid), .vec_rd(vec_rd), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rx_event(rx_event), .rx_buf_rd(rx_buf_rd),
  .ext_lvl(ext_lvl), .rx_clr_en(rx_clr_en), .ext_flag(ext_flag), .pin_s(pin_s)
);

// File: tb/tb_irq_front.sv
module tb_irq_front;
  logic        clk = 1'b0;
  logic        rst;
  logic        pin_in, rx_event, rx_buf_rd, wr_en, wr_addr, accept, vec_rd;
  logic [7:0]  wr_data;
  logic        ext_req, rx_req, vec_valid;
  logic [15:0] vec_out;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  irq_front dut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .rx_event(rx_event),
    .rx_buf_rd(rx_buf_rd), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .accept(accept), .vec_rd(vec_rd),
    .ext_req(ext_req), .rx_req(rx_req), .vec_out(vec_out),
    .vec_valid(vec_valid)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic pulse_rx(input bit rd);
    if (rd) rx_buf_rd = 1'b1; else rx_event = 1'b1;
    tick(1);
    rx_buf_rd = 1'b0; rx_event = 1'b0;
  endtask

  task automatic do_accept();
    accept = 1'b1; tick(1); accept = 1'b0;
  endtask

  task automatic do_vec_rd();
    vec_rd = 1'b1; tick(1); vec_rd = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ext_req", {15'd0, ext_req}, 16'd0);
    check("R1 rx_req", {15'd0, rx_req}, 16'd0);
    check("R1 vec_valid", {15'd0, vec_valid}, 16'd0);
  endtask

  task automatic t_edge();
    pin_in = 1'b1; tick(4);
    check("R2 rise sets", {15'd0, ext_req}, 16'd1);
    pin_in = 1'b0; tick(4);
    check("R2 held after fall", {15'd0, ext_req}, 16'd1);
    wr(1'b1, 8'h0B);
    check("R6 wrong code", {15'd0, ext_req}, 16'd1);
    wr(1'b1, 8'h0A);
    check("R6 clear code", {15'd0, ext_req}, 16'd0);
  endtask

  task automatic t_level();
    pin_in = 1'b1; tick(4);
    wr(1'b0, 8'h01);
    check("R3 level high", {15'd0, ext_req}, 16'd1);
    pin_in = 1'b0; tick(4);
    check("R3 level low", {15'd0, ext_req}, 16'd0);
    wr(1'b0, 8'h00);
    check("R5 flag survives", {15'd0, ext_req}, 16'd1);
    wr(1'b1, 8'h0A);
    check("R5 explicit clear", {15'd0, ext_req}, 16'd0);
  endtask

  task automatic t_mode_clear();
    pin_in = 1'b1; tick(4);
    pin_in = 1'b0; tick(4);
    check("R4 latched first", {15'd0, ext_req}, 16'd1);
    wr(1'b0, 8'h01);
    check("R4 level low", {15'd0, ext_req}, 16'd0);
    wr(1'b0, 8'h00);
    check("R4 flag cleared", {15'd0, ext_req}, 16'd0);
  endtask

  task automatic t_rx();
    wr(1'b0, 8'h00);
    pulse_rx(1'b0);
    check("R7 set", {15'd0, rx_req}, 16'd1);
    wr(1'b1, 8'h0B);
    check("R8 clear ignored", {15'd0, rx_req}, 16'd1);
    pulse_rx(1'b1);
    check("R7 read clears", {15'd0, rx_req}, 16'd0);
    pulse_rx(1'b0);
    wr(1'b0, 8'h02);
    wr(1'b1, 8'h0B);
    check("R9 clear enabled", {15'd0, rx_req}, 16'd0);
  endtask

  task automatic t_vector();
    wr(1'b0, 8'h02);
    pin_in = 1'b1; tick(4);
    pin_in = 1'b0; tick(1);
    pulse_rx(1'b0);
    do_accept();
    do_vec_rd();
    check("R10 valid", {15'd0, vec_valid}, 16'd1);
    check("R10 pin wins", vec_out, 16'h0028);
    tick(1);
    check("R12 single pulse", {15'd0, vec_valid}, 16'd0);
    wr(1'b1, 8'h0A);
    do_accept();
    do_vec_rd();
    check("R10 rx vector", vec_out, 16'h0030);
    do_accept();
    pulse_rx(1'b1);
    do_vec_rd();
    check("R11 default after clear", vec_out, 16'h0004);
    pulse_rx(1'b0);
    do_vec_rd();
    check("R12 no accept default", vec_out, 16'h0004);
  endtask

  initial begin
    rst = 1'b1; pin_in = 1'b0; rx_event = 1'b0; rx_buf_rd = 1'b0;
    wr_en = 1'b0; wr_addr = 1'b0; wr_data = 8'h00;
    accept = 1'b0; vec_rd = 1'b0;
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_edge();
    t_level();
    t_mode_clear();
    t_rx();
    t_vector();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule